// File: doc/BRIEF.md
# Processor Status Register Unit

This block keeps the 64-bit processor status word of a core and carries out the privileged operations that change or inspect it. Each cycle it can take one operation. The operation can OR bits into the low system-mask field, clear bits in that field, overwrite the lower 32-bit word, return a filtered copy of the register, or restore the whole register from a saved copy when an interruption handler returns.

Besides these operations, two hardware events keep a sticky flag at bit 4. This flag records that one of the lower floating-point registers was written. The first event is a floating-point writeback that targets registers 2 to 31. The second is the core leaving the legacy instruction mode while lower floating-point access is not disabled. Only an explicit write from software clears the flag. If the current privilege level is not 0, the operation is refused and a fault pulse is raised.

Top module: `psr_unit`

## Requirements
- R1: Operation code 0 (set mask) ORs `operand_i[23:0]` into register bits 23:0. Bits 63:24 are unchanged. The result is visible on `psr_o` after the next rising edge.
- R2: Operation code 1 (clear mask) clears each register bit in 23:0 whose operand bit is 1. Bits 63:24 are unchanged.
- R3: Operation code 2 (write lower word) replaces bits 31:0 with `operand_i[31:0]`. Bits 63:32 are unchanged.
- R4: Operation code 4 (restore) loads all 64 bits from `saved_psr_i` in one update.
- R5: Operation code 3 (read) pulses `rd_valid_o` for one cycle after the edge. `rd_data_o` then holds register bits 36:35 and 31:0 in their own positions, and every other bit is 0. The register is not changed. `rd_valid_o` is 0 after any cycle that has no read.
- R6: A cycle with `fp_lo_wr_i` high sets bit 4. Bit 4 stays set until an explicit write clears it.
- R7: A cycle with `leave_legacy_i` high and `dfl_i` low sets bit 4. When `dfl_i` is high, that event leaves bit 4 as it was.
- R8: An explicit write of bit 4 takes precedence over a setting event in the same cycle. Explicit writes are: a set or clear whose operand bit 4 is 1, a lower-word write, or a restore. If the event is still high in the next cycle, it sets bit 4 then.
- R9: A valid operation with `cpl_i` not 0 raises `priv_fault_o` for exactly one cycle. The operation has no effect: the register does not change and no read pulse appears.
- R10: Bit 0 is reserved. It always holds 0 and ignores every write and restore.
- R11: Reset clears the register to 0 and clears all outputs. A cycle with `op_valid_i` low changes nothing. Operation codes 5 to 7 also change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_valid_i | input | 1 | An operation is present this cycle |
| op_i | input | 3 | Operation code (0 set, 1 clear, 2 write lower, 3 read, 4 restore) |
| operand_i | input | 32 | Mask or lower-word value |
| saved_psr_i | input | 64 | Saved register image used by restore |
| cpl_i | input | 2 | Current privilege level, 0 is most privileged |
| fp_lo_wr_i | input | 1 | Writeback to floating-point register 2..31 completed |
| leave_legacy_i | input | 1 | Execution leaves the legacy instruction mode |
| dfl_i | input | 1 | Lower floating-point registers disabled |
| psr_o | output | 64 | Current register contents |
| rd_valid_o | output | 1 | Read result valid |
| rd_data_o | output | 64 | Filtered read result |
| priv_fault_o | output | 1 | Operation refused for privilege |

## Verification
The bench uses the default parameters: a 24-bit system mask, a 32-bit lower word, the sticky flag at bit 4, and a read window at bits 36:35. With these values the read window sits just above the field that a lower-word write can reach, so one restore value checks both the filtered read and the upper bits that writes must leave alone. The sticky flag sits inside the system mask, so set and clear operations can collide with the floating-point and mode-exit events in the same cycle.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int PSR_W = 64;

  typedef enum logic [2:0] {
    OP_SET_MASK = 3'd0,
    OP_CLR_MASK = 3'd1,
    OP_WRITE_LO = 3'd2,
    OP_READ     = 3'd3,
    OP_RESTORE  = 3'd4
  } psr_op_e;

  typedef struct packed {
    logic set_m;
    logic clr_m;
    logic wr_lo;
    logic rd;
    logic rfi;
  } psr_cmd_t;
endpackage

// File: rtl/psr_op_decode.sv
module psr_op_decode
  import psr_pkg::*;
#(
  parameter int CPL_W = 2
) (
  input  logic             op_valid_i,
  input  logic [2:0]       op_i,
  input  logic [CPL_W-1:0] cpl_i,
  output psr_cmd_t         cmd_o,
  output logic             fault_o
);
  logic priv_ok;

  assign priv_ok = (cpl_i == '0);
  assign fault_o = op_valid_i && !priv_ok;

  always_comb begin
    cmd_o = '0;
    if (op_valid_i && priv_ok) begin
      case (psr_op_e'(op_i))
        OP_SET_MASK: cmd_o.set_m = 1'b1;
        OP_CLR_MASK: cmd_o.clr_m = 1'b1;
        OP_WRITE_LO: cmd_o.wr_lo = 1'b1;
        OP_READ:     cmd_o.rd    = 1'b1;
        OP_RESTORE:  cmd_o.rfi   = 1'b1;
        default:     cmd_o       = '0;
      endcase
    end
  end
endmodule

// File: rtl/psr_next.sv
module psr_next
  import psr_pkg::*;
#(
  parameter int SYS_W   = 24,
  parameter int LO_W    = 32,
  parameter int MFL_BIT = 4
) (
  input  logic [PSR_W-1:0] psr_i,
  input  logic             set_m_i,
  input  logic             clr_m_i,
  input  logic             wr_lo_i,
  input  logic             rfi_i,
  input  logic [LO_W-1:0]  operand_i,
  input  logic [PSR_W-1:0] saved_i,
  input  logic             fp_lo_wr_i,
  input  logic             leave_legacy_i,
  input  logic             dfl_i,
  output logic [PSR_W-1:0] psr_o
);
  logic mfl_explicit;
  logic mfl_event;

  assign mfl_event = fp_lo_wr_i || (leave_legacy_i && !dfl_i);

  always_comb begin
    psr_o        = psr_i;
    mfl_explicit = 1'b0;
    if (set_m_i) begin
      psr_o[SYS_W-1:0] = psr_i[SYS_W-1:0] | operand_i[SYS_W-1:0];
      mfl_explicit     = operand_i[MFL_BIT];
    end else if (clr_m_i) begin
      psr_o[SYS_W-1:0] = psr_i[SYS_W-1:0] & ~operand_i[SYS_W-1:0];
      mfl_explicit     = operand_i[MFL_BIT];
    end else if (wr_lo_i) begin
      psr_o[LO_W-1:0] = operand_i;
      mfl_explicit    = 1'b1;
    end else if (rfi_i) begin
      psr_o        = saved_i;
      mfl_explicit = 1'b1;
    end
    // software write of the sticky bit beats a same-cycle hardware set
    if (mfl_event && !mfl_explicit) psr_o[MFL_BIT] = 1'b1;
    psr_o[0] = 1'b0;
  end
endmodule

// File: rtl/psr_read_mask.sv
module psr_read_mask
  import psr_pkg::*;
#(
  parameter int LO_W    = 32,
  parameter int RDH_LSB = 35,
  parameter int RDH_W   = 2
) (
  input  logic [PSR_W-1:0] psr_i,
  output logic [PSR_W-1:0] rd_o
);
  logic [PSR_W-1:0] mask;

  for (genvar b = 0; b < PSR_W; b++) begin : g_mask
    if (b == 0) begin : g_rsvd
      assign mask[b] = 1'b0;
    end else if (b < LO_W || (b >= RDH_LSB && b < RDH_LSB + RDH_W)) begin : g_vis
      assign mask[b] = 1'b1;
    end else begin : g_hid
      assign mask[b] = 1'b0;
    end
  end

  assign rd_o = psr_i & mask;
endmodule

// File: rtl/psr_unit.sv
module psr_unit
  import psr_pkg::*;
#(
  parameter int SYS_W   = 24,
  parameter int LO_W    = 32,
  parameter int MFL_BIT = 4,
  parameter int RDH_LSB = 35,
  parameter int RDH_W   = 2,
  parameter int CPL_W   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             op_valid_i,
  input  logic [2:0]       op_i,
  input  logic [LO_W-1:0]  operand_i,
  input  logic [PSR_W-1:0] saved_psr_i,
  input  logic [CPL_W-1:0] cpl_i,
  input  logic             fp_lo_wr_i,
  input  logic             leave_legacy_i,
  input  logic             dfl_i,
  output logic [PSR_W-1:0] psr_o,
  output logic             rd_valid_o,
  output logic [PSR_W-1:0] rd_data_o,
  output logic             priv_fault_o
);
  psr_cmd_t         cmd;
  logic             fault;
  logic [PSR_W-1:0] psr_q, psr_d, rd_view;

  psr_op_decode #(.CPL_W(CPL_W)) i_dec (
    .op_valid_i(op_valid_i), .op_i(op_i), .cpl_i(cpl_i),
    .cmd_o(cmd), .fault_o(fault)
  );

  psr_next #(.SYS_W(SYS_W), .LO_W(LO_W), .MFL_BIT(MFL_BIT)) i_next (
    .psr_i(psr_q), .set_m_i(cmd.set_m), .clr_m_i(cmd.clr_m),
    .wr_lo_i(cmd.wr_lo), .rfi_i(cmd.rfi), .operand_i(operand_i),
    .saved_i(saved_psr_i), .fp_lo_wr_i(fp_lo_wr_i),
    .leave_legacy_i(leave_legacy_i), .dfl_i(dfl_i), .psr_o(psr_d)
  );

  psr_read_mask #(.LO_W(LO_W), .RDH_LSB(RDH_LSB), .RDH_W(RDH_W)) i_rd (
    .psr_i(psr_q), .rd_o(rd_view)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psr_q        <= '0;
      rd_valid_o   <= 1'b0;
      rd_data_o    <= '0;
      priv_fault_o <= 1'b0;
    end else begin
      psr_q        <= psr_d;
      rd_valid_o   <= cmd.rd;
      priv_fault_o <= fault;
      if (cmd.rd) rd_data_o <= rd_view;
    end
  end

  assign psr_o = psr_q;

  AST_SET_HI_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && cpl_i == '0 && op_i == 3'd0) |=> $stable(psr_o[PSR_W-1:SYS_W])); // R1
  AST_CLR_HI_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && cpl_i == '0 && op_i == 3'd1) |=> $stable(psr_o[PSR_W-1:SYS_W])); // R2
  AST_WRLO_HI_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && cpl_i == '0 && op_i == 3'd2) |=> $stable(psr_o[PSR_W-1:LO_W])); // R3
  AST_RESTORE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && cpl_i == '0 && op_i == 3'd4)
      |=> psr_o[PSR_W-1:1] == $past(saved_psr_i[PSR_W-1:1])); // R4
  AST_READ_NO_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && cpl_i == '0 && op_i == 3'd3 && !fp_lo_wr_i && !leave_legacy_i)
      |=> $stable(psr_o)); // R5
  AST_FP_SETS_MFL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fp_lo_wr_i && !op_valid_i) |=> psr_o[MFL_BIT]); // R6
  AST_MFL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psr_o[MFL_BIT] && !op_valid_i) |=> psr_o[MFL_BIT]); // R6
  AST_FAULT_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    priv_fault_o |-> $past(op_valid_i && cpl_i != '0)); // R9
  AST_FAULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && cpl_i != '0 && !fp_lo_wr_i && !leave_legacy_i) |=> $stable(psr_o) && !rd_valid_o); // R9
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !psr_o[0] && !rd_data_o[0]); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!op_valid_i && !fp_lo_wr_i && !leave_legacy_i) |=> $stable(psr_o)); // R11
endmodule

// File: tb/test_psr_unit.sv
`timescale 1ns/1ps
module test_psr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op = '0;
  logic [31:0] operand = '0;
  logic [63:0] saved = '0;
  logic [1:0]  cpl = '0;
  logic        fp_wr = 1'b0, leave = 1'b0, dfl = 1'b0;
  logic [63:0] psr, rd_data;
  logic        rd_valid, fault;
  int          n_run = 0, n_fail = 0;
  logic [63:0] m;

  always #2 clk = ~clk;

  psr_unit i_psr_unit (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .op_i(op),
    .operand_i(operand), .saved_psr_i(saved), .cpl_i(cpl),
    .fp_lo_wr_i(fp_wr), .leave_legacy_i(leave), .dfl_i(dfl),
    .psr_o(psr), .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .priv_fault_o(fault)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one cycle of stimulus, inputs released at the following negedge
  task automatic step(input logic v, input logic [2:0] o, input logic [31:0] d,
                      input logic [1:0] c, input logic f, input logic l, input logic dd);
    @(negedge clk);
    op_valid = v; op = o; operand = d; cpl = c; fp_wr = f; leave = l; dfl = dd;
    @(negedge clk);
    op_valid = 0; fp_wr = 0; leave = 0; dfl = 0;
  endtask

  task automatic t_reset();
    chk("R11 reset psr", psr, 64'h0);
    chk("R11 reset flags", {62'h0, rd_valid, fault}, 64'h0);
  endtask

  task automatic t_restore();
    saved = 64'hDEAD_BEEF_0123_4567;
    step(1, 3'd4, '0, 0, 0, 0, 0);
    m = 64'hDEAD_BEEF_0123_4566;
    chk("R4 restore", psr, m);
    chk("R10 restore bit0", {63'h0, psr[0]}, 64'h0);
  endtask

  task automatic t_read();
    step(1, 3'd3, '0, 0, 0, 0, 0);
    chk("R5 read valid", {63'h0, rd_valid}, 64'h1);
    chk("R5 read data", rd_data, m & 64'h0000_0018_FFFF_FFFE);
    chk("R5 read no change", psr, m);
    @(negedge clk);
    chk("R5 read pulse ends", {63'h0, rd_valid}, 64'h0);
  endtask

  task automatic t_set_clear();
    step(1, 3'd0, 32'hFFFF_FFFF, 0, 0, 0, 0);
    m[23:1] = '1;
    chk("R1 set mask", psr, m);
    step(1, 3'd1, 32'hFFAA_AAAA, 0, 0, 0, 0);
    m[23:0] = m[23:0] & ~24'hAAAAAA;
    chk("R2 clear mask", psr, m);
  endtask

  task automatic t_write_lo();
    step(1, 3'd2, 32'h1357_9BDF, 0, 0, 0, 0);
    m[31:0] = 32'h1357_9BDE;
    chk("R3 write lower", psr, m);
    chk("R10 write bit0", {63'h0, psr[0]}, 64'h0);
  endtask

  task automatic t_mfl();
    step(1, 3'd2, 32'h0, 0, 0, 0, 0);
    m[31:0] = 0;
    step(0, 3'd0, '0, 0, 1, 0, 0);
    chk("R6 fp event sets", psr, m | 64'h10);
    repeat (3) @(negedge clk);
    chk("R6 sticky", psr, m | 64'h10);
    step(1, 3'd1, 32'h10, 0, 0, 0, 0);
    chk("R6 explicit clear", psr, m);
    step(0, 3'd0, '0, 0, 0, 1, 1);
    chk("R7 leave with dfl", psr, m);
    step(0, 3'd0, '0, 0, 0, 1, 0);
    chk("R7 leave without dfl", psr, m | 64'h10);
  endtask

  task automatic t_collide();
    // psr bit4 set on entry
    @(negedge clk);
    op_valid = 1; op = 3'd1; operand = 32'h10; cpl = 0; fp_wr = 1;
    @(negedge clk);
    op_valid = 0;
    chk("R8 clear beats event", psr, m);
    @(negedge clk);
    fp_wr = 0;
    chk("R8 event reapplied", psr, m | 64'h10);
    step(1, 3'd0, 32'h2, 0, 1, 0, 0);
    chk("R8 set without bit4 keeps event", psr, m | 64'h12);
    step(1, 3'd2, 32'h0, 0, 0, 1, 0);
    m[31:0] = 0;
    chk("R8 lower write beats leave", psr, m);
  endtask

  task automatic t_priv();
    step(1, 3'd2, 32'h0000_00FC, 3, 0, 0, 0);
    chk("R9 fault pulse", {63'h0, fault}, 64'h1);
    chk("R9 no write", psr, m);
    @(negedge clk);
    chk("R9 fault one cycle", {63'h0, fault}, 64'h0);
    step(1, 3'd3, '0, 1, 0, 0, 0);
    chk("R9 no read pulse", {62'h0, rd_valid, fault}, 64'h1);
  endtask

  task automatic t_idle();
    step(0, 3'd4, 32'hFFFF_FFFF, 0, 0, 0, 0);
    chk("R11 invalid op ignored", psr, m);
    step(1, 3'd6, 32'hFFFF_FFFF, 0, 0, 0, 0);
    chk("R11 unused code ignored", psr, m);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_restore();
    t_read();
    t_set_clear();
    t_write_lo();
    t_mfl();
    t_collide();
    t_priv();
    t_idle();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule